// File: doc/BRIEF.md
# Serial-Parallel-Serial Line Delay Memory

This block delays a one-bit serial stream by a long, fixed number of bit clocks without addressing. Incoming bits are dealt out in turn to a set of identical sections. Each section collects its share in a serial input register. Once that register is full, the whole row moves in one step into a deep row store. At the same moment, the oldest row in the store moves into a serial output register, which is then shifted out. The section outputs are interleaved back into one stream in the same order the input was dealt out. Because data crosses the store as whole rows, the store steps only once for every row width of a section's bits.

A line-sync input restarts the dealing pointer and the bit position, so the memory can be locked to line timing. A loop mode feeds the output back to the input through a short, selectable realignment delay. In that mode a stored picture repeats forever, and the external data input is ignored.

Top module: `serpar_delay_mem`

## Requirements
- R1: With loop mode off and no line sync since slot zero, the value of `dout` after clock edge e equals `din` sampled at edge e-L, where L = (DEPTH+1)*SECTIONS*ROW_BITS bit clocks.
- R2: Consecutive bits go to sections 0, 1, ..., SECTIONS-1 in turn. The row bit position advances by one after section SECTIONS-1 and wraps from ROW_BITS-1 to 0.
- R3: A bit sampled with `line_sync` high is slot zero (section 0, bit position 0). Bits sampled from that edge onward appear at `dout` with latency L, for every output edge from L edges after the sync.
- R4: Synchronous reset drives `dout` to 0 and sets the slot counters to slot zero, so the first bit after reset is slot zero even without a line sync.
- R5: With `recirc` high, the bit stored at edge e is the `dout` value produced at edge e-1-`fb_delay`. A stored pattern therefore repeats with a period of L+1+`fb_delay` bit clocks.
- R6: While `recirc` is high, the value on `din` has no effect on `dout`.
- R7: `fb_delay` selects any extra feedback delay from 0 to MAX_FB bits (3 bits wide for the default of 7). Each setting gives its own repeat period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| line_sync | input | 1 | Marks the current bit as slot zero of a line |
| din | input | 1 | Serial data in |
| recirc | input | 1 | Loop mode: store the fed-back output instead of `din` |
| fb_delay | input | $clog2(MAX_FB+1) | Extra feedback delay in bits, 0 to MAX_FB |
| dout | output | 1 | Serial data out, registered |

## Verification
A fault in the slot counters or in one section's row pointer does not stay hidden. It shows at `dout` exactly one latency L after the first bit it touched, and it shows as bits out of order or swapped between interleaved positions. The bench therefore compares every output bit against an ideal delay line once L edges have passed. A wrong feedback tap shows up only after one full loop period of L+1+`fb_delay` bits, as a pattern that has shifted or decayed. For that reason, the loop tests run for several periods.

// File: rtl/spsd_pkg.sv
package spsd_pkg;

    typedef enum logic {
        SRC_EXTERNAL = 1'b0,
        SRC_LOOP     = 1'b1
    } src_sel_e;

    function automatic int unsigned line_latency(input int unsigned n_sec,
                                                 input int unsigned row_bits,
                                                 input int unsigned depth);
        return (depth + 1) * n_sec * row_bits;
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/spsd_section.sv
module spsd_section #(
    parameter int unsigned ROW_BITS = 128,
    parameter int unsigned DEPTH    = 170
) (
    input  logic clk,
    input  logic rst,
    input  logic turn,
    input  logic row_end,
    input  logic bit_in,
    output logic bit_out
);
    localparam int unsigned PW = spsd_pkg::cnt_bits(DEPTH);

    logic [ROW_BITS-1:0] in_sr;
    logic [ROW_BITS-1:0] out_sr;
    logic [ROW_BITS-1:0] store [DEPTH];
    logic [PW-1:0]       ptr;
    logic [ROW_BITS-1:0] row_in;
    logic                xfer;

    assign row_in  = {bit_in, in_sr[ROW_BITS-1:1]};
    assign xfer    = turn & row_end;
    assign bit_out = out_sr[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            in_sr  <= '0;
            out_sr <= '0;
            ptr    <= '0;
        end else if (turn) begin
            in_sr <= row_in;
            if (row_end) begin
                out_sr <= store[ptr];
                ptr    <= (ptr == PW'(DEPTH - 1)) ? '0 : ptr + PW'(1);
            end else begin
                out_sr <= {1'b0, out_sr[ROW_BITS-1:1]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (xfer) begin
            store[ptr] <= row_in;
        end
    end

endmodule

// File: rtl/spsd_loop_delay.sv
module spsd_loop_delay #(
    parameter int unsigned MAX_FB = 7
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bit_in,
    input  logic [$clog2(MAX_FB+1)-1:0]  sel,
    output logic                         bit_out
);
    logic [MAX_FB-1:0] taps;

    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else begin
            taps <= {taps[MAX_FB-2:0], bit_in};
        end
    end

    always_comb begin
        if (sel == '0) begin
            bit_out = bit_in;
        end else begin
            bit_out = taps[sel - 1'b1];
        end
    end

endmodule

// File: rtl/serpar_delay_mem.sv
module serpar_delay_mem #(
    parameter int unsigned SECTIONS = 8,
    parameter int unsigned ROW_BITS = 128,
    parameter int unsigned DEPTH    = 170,
    parameter int unsigned MAX_FB   = 7
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         line_sync,
    input  logic                         din,
    input  logic                         recirc,
    input  logic [$clog2(MAX_FB+1)-1:0]  fb_delay,
    output logic                         dout
);
    import spsd_pkg::*;

    localparam int unsigned NB = cnt_bits(SECTIONS);
    localparam int unsigned WB = cnt_bits(ROW_BITS);

    logic [NB-1:0]       sel_q, cur_sel;
    logic [WB-1:0]       idx_q, cur_idx;
    logic                row_end;
    logic                fb;
    logic                bit_in;
    src_sel_e            src;
    logic [SECTIONS-1:0] sec_out;
    logic                dout_q;

    // Slot zero is forced by line_sync in the same cycle
    always_comb begin
        cur_sel = line_sync ? '0 : sel_q;
        cur_idx = line_sync ? '0 : idx_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            idx_q <= '0;
        end else if (cur_sel == NB'(SECTIONS - 1)) begin
            sel_q <= '0;
            idx_q <= (cur_idx == WB'(ROW_BITS - 1)) ? '0 : cur_idx + WB'(1);
        end else begin
            sel_q <= cur_sel + NB'(1);
            idx_q <= cur_idx;
        end
    end

    assign row_end = (cur_idx == WB'(ROW_BITS - 1));
    assign src     = recirc ? SRC_LOOP : SRC_EXTERNAL;
    assign bit_in  = (src == SRC_LOOP) ? fb : din;

    for (genvar g = 0; g < SECTIONS; g++) begin : g_sec
        spsd_section #(
            .ROW_BITS (ROW_BITS),
            .DEPTH    (DEPTH)
        ) u_sec (
            .clk     (clk),
            .rst     (rst),
            .turn    (cur_sel == NB'(g)),
            .row_end (row_end),
            .bit_in  (bit_in),
            .bit_out (sec_out[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= 1'b0;
        end else begin
            dout_q <= sec_out[cur_sel];
        end
    end

    assign dout = dout_q;

    spsd_loop_delay #(
        .MAX_FB (MAX_FB)
    ) u_loop (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (dout_q),
        .sel     (fb_delay),
        .bit_out (fb)
    );

endmodule

// File: rtl/spsd_checker.sv
module spsd_checker #(
    parameter int unsigned SECTIONS = 8,
    parameter int unsigned ROW_BITS = 128,
    parameter int unsigned MAX_FB   = 7,
    parameter int unsigned NB       = 3,
    parameter int unsigned WB       = 7
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         line_sync,
    input logic [NB-1:0]                sel_q,
    input logic [WB-1:0]                idx_q,
    input logic [$clog2(MAX_FB+1)-1:0]  fb_delay,
    input logic                         dout,
    input logic                         fb
);

    assert_sync_restart_R3: assert property (@(posedge clk) disable iff (rst)
        line_sync |=> (sel_q == NB'(1) && idx_q == '0));

    assert_round_robin_R2: assert property (@(posedge clk) disable iff (rst)
        (!line_sync && sel_q != NB'(SECTIONS - 1))
        |=> (sel_q == $past(sel_q) + NB'(1) && idx_q == $past(idx_q)));

    assert_row_advance_R2: assert property (@(posedge clk) disable iff (rst)
        (!line_sync && sel_q == NB'(SECTIONS - 1) && idx_q != WB'(ROW_BITS - 1))
        |=> (sel_q == '0 && idx_q == $past(idx_q) + WB'(1)));

    assert_row_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (!line_sync && sel_q == NB'(SECTIONS - 1) && idx_q == WB'(ROW_BITS - 1))
        |=> (sel_q == '0 && idx_q == '0));

    assert_loop_tap_R7: assert property (@(posedge clk) disable iff (rst)
        (fb_delay == 1) |-> (fb == $past(dout)));

endmodule

bind serpar_delay_mem spsd_checker #(
    .SECTIONS (SECTIONS),
    .ROW_BITS (ROW_BITS),
    .MAX_FB   (MAX_FB),
    .NB       (NB),
    .WB       (WB)
) u_spsd_checker (
    .clk       (clk),
    .rst       (rst),
    .line_sync (line_sync),
    .sel_q     (sel_q),
    .idx_q     (idx_q),
    .fb_delay  (fb_delay),
    .dout      (dout),
    .fb        (fb)
);

// File: tb/serpar_delay_mem_bench.sv
`timescale 1ns/1ps
module serpar_delay_mem_bench;

    localparam int unsigned SECTIONS = 4;
    localparam int unsigned ROW_BITS = 8;
    localparam int unsigned DEPTH    = 6;
    localparam int unsigned MAX_FB   = 7;
    localparam int          L        = (DEPTH + 1) * SECTIONS * ROW_BITS;
    localparam int          HMAX     = 16384;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_sync = 1'b0;
    logic       din = 1'b0;
    logic       recirc = 1'b0;
    logic [2:0] fb_delay = 3'd0;
    logic       dout;

    int tests = 0;
    int fails = 0;
    int e = 0;
    int chk_from = L;

    bit mdl_in  [HMAX];
    bit mdl_out [HMAX];

    always #2.5 clk = ~clk;

    serpar_delay_mem #(
        .SECTIONS (SECTIONS),
        .ROW_BITS (ROW_BITS),
        .DEPTH    (DEPTH),
        .MAX_FB   (MAX_FB)
    ) u_serpar_delay_mem (
        .clk       (clk),
        .rst       (rst),
        .line_sync (line_sync),
        .din       (din),
        .recirc    (recirc),
        .fb_delay  (fb_delay),
        .dout      (dout)
    );

    task automatic check(input bit act, input bit exp, input string req);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s edge %0d: dout=%0b expected %0b", req, e, act, exp);
        end
    endtask

    // Drive one bit clock at a negedge, then check the result at the next negedge
    task automatic tick(input bit d, input bit rc, input int k, input bit sy, input string req);
        din = d;
        recirc = rc;
        fb_delay = 3'(k);
        line_sync = sy;
        if (sy) chk_from = e + L;
        if (rc) mdl_in[e] = (e - 1 - k >= 0) ? mdl_out[e - 1 - k] : 1'b0;
        else    mdl_in[e] = d;
        mdl_out[e] = (e >= L) ? mdl_in[e - L] : 1'b0;
        @(negedge clk);
        if (e >= chk_from) check(dout, mdl_out[e], req);
        e++;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check(dout, 1'b0, "R4 reset dout");
        rst = 1'b0;
    endtask

    // R4: no line_sync after reset, first bit must be slot zero; R1 random data
    task automatic t_stream_random();
        for (int i = 0; i < 3 * L; i++) tick(1'($urandom), 1'b0, 0, 1'b0, "R1 R4 random stream");
    endtask

    // R1, R2: fixed patterns exercise bit order across sections and rows
    task automatic t_patterns();
        for (int i = 0; i < L; i++) tick(1'b1, 1'b0, 0, 1'b0, "R1 all ones");
        for (int i = 0; i < L; i++) tick(1'(i % 2), 1'b0, 0, 1'b0, "R2 alternating");
        for (int i = 0; i < 2 * L; i++) tick(1'((i % 37) == 0), 1'b0, 0, 1'b0, "R2 sparse ones");
    endtask

    // R3: resync in the middle of a row
    task automatic t_resync();
        for (int i = 0; i < 13; i++) tick(1'($urandom), 1'b0, 0, 1'b0, "R3 pre-sync");
        tick(1'b1, 1'b0, 0, 1'b1, "R3 sync bit");
        for (int i = 0; i < 2 * L; i++) tick(1'($urandom), 1'b0, 0, 1'b0, "R3 after resync");
        tick(1'b0, 1'b0, 0, 1'b1, "R3 aligned sync");
        for (int i = 0; i < L + 40; i++) tick(1'($urandom), 1'b0, 0, 1'b0, "R3 aligned resync");
    endtask

    // R5: loop with no extra delay, din held at constant zero
    task automatic t_loop_direct();
        for (int i = 0; i < 3 * L; i++) tick(1'b0, 1'b1, 0, 1'b0, "R5 loop fb_delay=0");
        for (int i = 0; i < L + 8; i++) tick(1'($urandom), 1'b0, 0, 1'b0, "R5 refill");
    endtask

    // R6, R7: loop with realignment delay while din toggles randomly
    task automatic t_loop_delayed(input int k);
        for (int i = 0; i < 3 * L; i++) tick(1'($urandom), 1'b1, k, 1'b0, "R6 R7 loop ignores din");
        for (int i = 0; i < L + 8; i++) tick(1'($urandom), 1'b0, k, 1'b0, "R7 refill");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_stream_random();
        t_patterns();
        t_resync();
        t_loop_direct();
        t_loop_delayed(5);
        t_loop_delayed(7);
        t_loop_delayed(1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule